// File: doc/BRIEF.md
# Autoprecharge SDRAM access sequencer

This block sits between a single host and one rank of synchronous DRAM. It never leaves a row open. Every host read or write opens the addressed row with an ACTIVE command and waits the row-to-column delay. It then issues the column command with the autoprecharge address bit set and moves a two-beat burst. After that it returns to idle with every bank already closing. Power-up initialisation and mode-register setup are assumed to be done elsewhere, with burst length two programmed.

Because no bank is ever left open, a periodic refresh needs no precharge. A free-running interval timer raises a pending flag, and the sequencer slots an AUTO REFRESH in at the next idle decision, ahead of any waiting host request. It then observes the refresh cycle time before it accepts new work. The host may abort a burst while data is moving. The sequencer then drives BURST TERMINATE in that cycle and goes straight back to idle.

The host presents `req_i` with direction, address `{bank,row,col}` and a 2×DQ-wide write word. The request is taken on a clock edge where `req_i` is high and `busy_o` is low. Read data comes back on `rdata_o`, qualified by a one-cycle `rvalid_o`.

Top module: `sdram_ap_ctrl`

## Requirements
- R1: Every host access begins with an ACTIVE command that carries the bank and row fields of the request. This holds even when the previous access used the same bank and row.
- R2: The column command is READ or WRITE. It carries the same bank, the column on the low address bits and address bit 10 high (autoprecharge). Pins {cs_n,ras_n,cas_n,we_n} encode NOP=0111, ACTIVE=0011, READ=0101, WRITE=0100, BURST TERMINATE=0110, AUTO REFRESH=0001.
- R3: On a write, `wdata_i[DQ_W-1:0]` is driven with the WRITE command and `wdata_i[2*DQ_W-1:DQ_W]` in the following cycle. `dq_oe_o` is high in exactly those two cycles, and the cycle after is a NOP.
- R4: On a read, `dq_i` is sampled CAS_LAT and CAS_LAT+1 cycles after READ into the low and high halves of `rdata_o`. `rvalid_o` is high for exactly one cycle, CAS_LAT+2 cycles after READ.
- R5: The column command follows the ACTIVE command by exactly T_RCD cycles.
- R6: `abort_i` high during either data cycle puts BURST TERMINATE on the pins in that same cycle with `dq_oe_o` low. The next cycle is idle (NOP, `busy_o` low) and `rvalid_o` is not raised for that access.
- R7: `abort_i` outside the two data cycles has no effect: the access completes with correct data and `rvalid_o`.
- R8: With no host traffic, AUTO REFRESH is issued every REF_INT cycles with no other command in between. It is never issued while a row is open.
- R9: A pending refresh wins over a waiting request at the idle decision. The waiting request's ACTIVE follows the AUTO REFRESH by exactly T_RFC+1 cycles.
- R10: `busy_o` is high from the cycle after acceptance until the sequencer is idle again. It is also high while a refresh is pending or running, and whenever a non-NOP command is on the pins.
- R11: During reset the pins show NOP, and `busy_o`, `rvalid_o` and `dq_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | BANK_W+ROW_W+COL_W | {bank,row,col} |
| wdata_i | input | 2*DQ_W | Write burst, low half first |
| abort_i | input | 1 | End current burst early |
| rdata_o | output | 2*DQ_W | Read burst, low half first beat |
| rvalid_o | output | 1 | Read data valid pulse |
| busy_o | output | 1 | Request cannot be taken |
| cs_n_o | output | 1 | Chip select, low active |
| ras_n_o | output | 1 | Row strobe, low active |
| cas_n_o | output | 1 | Column strobe, low active |
| we_n_o | output | 1 | Write enable, low active |
| ba_o | output | BANK_W | Bank select |
| sd_addr_o | output | ROW_W | Memory address bus |
| dq_o | output | DQ_W | Data driven to memory |
| dq_oe_o | output | 1 | Data output enable |
| dq_i | input | DQ_W | Data returned from memory |

## Verification
Every cycle, the assertions check these properties of the pins:
- the ACTIVE-to-column spacing;
- the autoprecharge bit;
- that no ACTIVE or AUTO REFRESH is issued while a row is still open;
- that an abort in a data cycle gives BURST TERMINATE and then idle;
- that output enable appears only with or right after WRITE;
- that `busy_o` covers every command;
- that `rvalid_o` lasts a single cycle.

Only the bench scenarios show the rest. These are the data values on both burst beats, the read capture timing against a memory model, and that an abort outside the data phase is ignored. They also cover the refresh interval, and refresh winning over a held request followed by the exact T_RFC recovery.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ACT, ST_RCD, ST_CMD, ST_CLW, ST_D1, ST_D2, ST_REF, ST_RFW
  } state_e;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_BST, C_REF
  } cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    case (c)
      C_ACT:   return 4'b0011;
      C_RD:    return 4'b0101;
      C_WR:    return 4'b0100;
      C_BST:   return 4'b0110;
      C_REF:   return 4'b0001;
      default: return 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_wait_cnt.sv
module sdr_wait_cnt #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= val_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - 1'b1;
  end

  // high in the final wait cycle
  assign last_o = (cnt_q <= W'(1));
endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int REF_INT = 780
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = (REF_INT > 2) ? $clog2(REF_INT) : 1;

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          expire;

  assign expire = (cnt_q == CW'(REF_INT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= expire ? '0 : cnt_q + 1'b1;
      pend_q <= expire | (pend_q & ~ack_i);
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sdr_cmd_drive.sv
module sdr_cmd_drive import sdr_pkg::*; #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DQ_W   = 16
) (
  input  state_e              st_i,
  input  logic                we_i,
  input  logic                abort_i,
  input  logic [BANK_W-1:0]   bank_i,
  input  logic [ROW_W-1:0]    row_i,
  input  logic [COL_W-1:0]    col_i,
  input  logic [2*DQ_W-1:0]   wdata_i,
  output logic                cs_n_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic [BANK_W-1:0]   ba_o,
  output logic [ROW_W-1:0]    sd_addr_o,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dq_oe_o
);
  localparam int AP_BIT = 10;

  cmd_e cmd;

  always_comb begin
    cmd       = C_NOP;
    ba_o      = '0;
    sd_addr_o = '0;
    dq_o      = '0;
    dq_oe_o   = 1'b0;
    case (st_i)
      ST_ACT: begin
        cmd       = C_ACT;
        ba_o      = bank_i;
        sd_addr_o = row_i;
      end
      ST_CMD: begin
        cmd                    = we_i ? C_WR : C_RD;
        ba_o                   = bank_i;
        sd_addr_o[COL_W-1:0]   = col_i;
        sd_addr_o[AP_BIT]      = 1'b1;
        if (we_i) begin
          dq_o    = wdata_i[DQ_W-1:0];
          dq_oe_o = 1'b1;
        end
      end
      ST_D1: begin
        if (abort_i) cmd = C_BST;
        else if (we_i) begin
          dq_o    = wdata_i[2*DQ_W-1:DQ_W];
          dq_oe_o = 1'b1;
        end
      end
      ST_D2:  if (abort_i) cmd = C_BST;
      ST_REF: cmd = C_REF;
      default: cmd = C_NOP;
    endcase
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_pins(cmd);
endmodule

// File: rtl/sdram_ap_ctrl.sv
module sdram_ap_ctrl import sdr_pkg::*; #(
  parameter int BANK_W  = 2,
  parameter int ROW_W   = 12,   // >= 11, bit 10 is the autoprecharge flag
  parameter int COL_W   = 8,    // <= 10
  parameter int DQ_W    = 16,
  parameter int T_RCD   = 2,    // >= 1
  parameter int CAS_LAT = 2,    // >= 1
  parameter int T_RFC   = 4,    // >= 1
  parameter int REF_INT = 780,  // 15.6 us at 50 MHz
  localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [2*DQ_W-1:0]   wdata_i,
  input  logic                abort_i,
  output logic [2*DQ_W-1:0]   rdata_o,
  output logic                rvalid_o,
  output logic                busy_o,
  output logic                cs_n_o,
  output logic                ras_n_o,
  output logic                cas_n_o,
  output logic                we_n_o,
  output logic [BANK_W-1:0]   ba_o,
  output logic [ROW_W-1:0]    sd_addr_o,
  output logic [DQ_W-1:0]     dq_o,
  output logic                dq_oe_o,
  input  logic [DQ_W-1:0]     dq_i
);
  localparam int MAXA = (T_RCD > CAS_LAT) ? T_RCD : CAS_LAT;
  localparam int MAXD = (MAXA > T_RFC) ? MAXA : T_RFC;
  localparam int WW   = $clog2(MAXD + 1);

  state_e              st_q, st_d;
  logic                we_q;
  logic [BANK_W-1:0]   bank_q;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q;
  logic [2*DQ_W-1:0]   wdata_q;
  logic [2*DQ_W-1:0]   rdata_q;
  logic                rvalid_q;
  logic                ref_pend;
  logic                accept;
  logic                wait_load;
  logic [WW-1:0]       wait_val;
  logic                wait_last;
  logic                in_data;

  assign accept  = (st_q == ST_IDLE) && !ref_pend && req_i;
  assign in_data = (st_q == ST_D1) || (st_q == ST_D2);

  sdr_ref_timer #(.REF_INT(REF_INT)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (st_q == ST_REF),
    .pend_o (ref_pend)
  );

  always_comb begin
    wait_load = 1'b1;
    case (st_q)
      ST_ACT:  wait_val = WW'(T_RCD - 1);
      ST_CMD:  wait_val = WW'(CAS_LAT - 1);
      ST_REF:  wait_val = WW'(T_RFC - 1);
      default: begin
        wait_val  = '0;
        wait_load = 1'b0;
      end
    endcase
  end

  sdr_wait_cnt #(.W(WW)) u_wait (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (wait_load),
    .val_i  (wait_val),
    .last_o (wait_last)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: begin
        if (ref_pend)   st_d = ST_REF;
        else if (req_i) st_d = ST_ACT;
      end
      ST_ACT:  st_d = (T_RCD <= 1) ? ST_CMD : ST_RCD;
      ST_RCD:  if (wait_last) st_d = ST_CMD;
      ST_CMD: begin
        if (we_q || CAS_LAT <= 1) st_d = ST_D1;
        else                      st_d = ST_CLW;
      end
      ST_CLW:  if (wait_last) st_d = ST_D1;
      ST_D1:   st_d = abort_i ? ST_IDLE : ST_D2;
      ST_D2:   st_d = ST_IDLE;
      ST_REF:  st_d = (T_RFC <= 1) ? ST_IDLE : ST_RFW;
      ST_RFW:  if (wait_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      we_q    <= 1'b0;
      bank_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        we_q                    <= we_i;
        {bank_q, row_q, col_q}  <= addr_i;
        wdata_q                 <= wdata_i;
      end
    end
  end

  // read capture: beat 0 in D1, beat 1 in D2
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= 1'b0;
      if (!we_q && st_q == ST_D1) rdata_q[DQ_W-1:0] <= dq_i;
      if (!we_q && st_q == ST_D2 && !abort_i) begin
        rdata_q[2*DQ_W-1:DQ_W] <= dq_i;
        rvalid_q               <= 1'b1;
      end
    end
  end

  sdr_cmd_drive #(
    .BANK_W (BANK_W),
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DQ_W   (DQ_W)
  ) u_drv (
    .st_i      (st_q),
    .we_i      (we_q),
    .abort_i   (abort_i & in_data),
    .bank_i    (bank_q),
    .row_i     (row_q),
    .col_i     (col_q),
    .wdata_i   (wdata_q),
    .cs_n_o    (cs_n_o),
    .ras_n_o   (ras_n_o),
    .cas_n_o   (cas_n_o),
    .we_n_o    (we_n_o),
    .ba_o      (ba_o),
    .sd_addr_o (sd_addr_o),
    .dq_o      (dq_o),
    .dq_oe_o   (dq_oe_o)
  );

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign busy_o   = (st_q != ST_IDLE) || ref_pend;
endmodule

// File: rtl/sdram_ap_ctrl_chk.sv
module sdram_ap_ctrl_chk import sdr_pkg::*; #(
  parameter int T_RCD = 2,
  parameter int ROW_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [ROW_W-1:0] sd_addr_o,
  input logic             dq_oe_o,
  input logic             busy_o,
  input logic             rvalid_o,
  input logic             abort_i,
  input state_e           st_i
);
  logic [3:0] pins;
  logic       is_col;
  logic       row_open;
  logic [7:0] since_act;

  assign pins   = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign is_col = (pins == 4'b0101) || (pins == 4'b0100);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open  <= 1'b0;
      since_act <= 8'hFF;
    end else begin
      if (pins == 4'b0011)     row_open <= 1'b1;
      else if (is_col)         row_open <= 1'b0;
      if (pins == 4'b0011)     since_act <= 8'd1;
      else if (since_act != 8'hFF) since_act <= since_act + 8'd1;
    end
  end

  p_act_to_col_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> since_act == 8'(T_RCD));

  p_autopre_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_col |-> sd_addr_o[10]);

  p_act_closed_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0011) |-> !row_open);

  p_abort_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_D1 || st_i == ST_D2) && abort_i) |-> (pins == 4'b0110 && !dq_oe_o));

  p_abort_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_i == ST_D1 || st_i == ST_D2) && abort_i) |=> st_i == ST_IDLE);

  p_ref_closed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins == 4'b0001) |-> !row_open);

  p_busy_cmd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins != 4'b0111) |-> busy_o);

  p_oe_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (pins == 4'b0100 || $past(pins) == 4'b0100));

  p_rvalid_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
endmodule

bind sdram_ap_ctrl sdram_ap_ctrl_chk #(.T_RCD(T_RCD), .ROW_W(ROW_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_n_o    (cs_n_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .we_n_o    (we_n_o),
  .sd_addr_o (sd_addr_o),
  .dq_oe_o   (dq_oe_o),
  .busy_o    (busy_o),
  .rvalid_o  (rvalid_o),
  .abort_i   (abort_i),
  .st_i      (st_q)
);

// File: tb/tb_sdram_ap_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_ap_ctrl;
  localparam int BANK_W  = 2;
  localparam int ROW_W   = 12;
  localparam int COL_W   = 8;
  localparam int DQ_W    = 16;
  localparam int T_RCD   = 2;
  localparam int CAS_LAT = 2;
  localparam int T_RFC   = 4;
  localparam int REF_INT = 1500;
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W;

  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_BST = 4'b0110, P_REF = 4'b0001;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0, abort_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [2*DQ_W-1:0] wdata_i = '0;
  logic [2*DQ_W-1:0] rdata_o;
  logic rvalid_o, busy_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, dq_oe_o;
  logic [BANK_W-1:0] ba_o;
  logic [ROW_W-1:0]  sd_addr_o;
  logic [DQ_W-1:0]   dq_o;
  logic [DQ_W-1:0]   dq_i = '0;
  logic [3:0] pins;

  assign pins = {cs_n_o, ras_n_o, cas_n_o, we_n_o};

  always #10 clk_i = ~clk_i;

  sdram_ap_ctrl #(
    .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W),
    .T_RCD(T_RCD), .CAS_LAT(CAS_LAT), .T_RFC(T_RFC), .REF_INT(REF_INT)
  ) dut (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .abort_i,
    .rdata_o, .rvalid_o, .busy_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o,
    .ba_o, .sd_addr_o, .dq_o, .dq_oe_o, .dq_i
  );

  int n_cmp = 0;
  int n_err = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DQ_W-1:0] pat(input logic [1:0] b, input logic [11:0] r,
                                          input logic [7:0] c, input int beat);
    return {r, b, 2'b01} ^ {c + 8'(beat), c ^ 8'(beat * 8'h5a)};
  endfunction

  // memory model: tracks open rows, returns pattern data CAS_LAT after READ
  logic [ROW_W-1:0] open_row [4];
  int rd_at = -10;
  logic [1:0] rd_b;
  logic [11:0] rd_r;
  logic [7:0] rd_c;

  always @(negedge clk_i) begin
    if (cyc == rd_at)          dq_i = pat(rd_b, rd_r, rd_c, 0);
    else if (cyc == rd_at + 1) dq_i = pat(rd_b, rd_r, rd_c, 1);
    else                       dq_i = '0;
    if (rst_ni && pins == P_ACT) open_row[ba_o] = sd_addr_o;
    if (rst_ni && pins == P_RD) begin
      rd_at = cyc + CAS_LAT;
      rd_b  = ba_o;
      rd_r  = open_row[ba_o];
      rd_c  = sd_addr_o[COL_W-1:0];
    end
  end

  // ab: 0 none, 1 abort in D1, 2 abort in D2, 3 abort held during ACTIVE
  task automatic do_acc(input bit wr, input logic [1:0] b, input logic [11:0] r,
                        input logic [7:0] c, input logic [31:0] wd, input int ab);
    int n;
    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    req_i = 1; we_i = wr; addr_i = {b, r, c}; wdata_i = wd;
    @(negedge clk_i);
    req_i = 0;
    chk(pins == P_ACT, "R1", "activate first", pins, P_ACT);
    chk(ba_o == b && sd_addr_o == r, "R1", "activate bank/row", {ba_o, sd_addr_o}, {b, r});
    chk(busy_o, "R10", "busy after accept", busy_o, 1);
    if (ab == 3) abort_i = 1;
    n = 0;
    do begin
      @(negedge clk_i);
      abort_i = 0;
      n++;
    end while (pins == P_NOP && n < 20);
    chk(n == T_RCD, "R5", "act to column", n, T_RCD);
    chk(pins == (wr ? P_WR : P_RD), "R2", "column cmd", pins, wr ? P_WR : P_RD);
    chk(sd_addr_o[10] && sd_addr_o[COL_W-1:0] == c && ba_o == b, "R2", "column addr/ap",
        {ba_o, sd_addr_o}, {b, 4'b0100, c});
    if (wr) begin
      chk(dq_oe_o && dq_o == wd[15:0], "R3", "write beat0", {dq_oe_o, dq_o}, {1'b1, wd[15:0]});
      @(negedge clk_i);
      if (ab == 1) begin
        abort_i = 1; #1;
        chk(pins == P_BST && !dq_oe_o, "R6", "write abort stop", {pins, dq_oe_o}, {P_BST, 1'b0});
        @(negedge clk_i);
        abort_i = 0;
        chk(pins == P_NOP && !busy_o && !dq_oe_o, "R6", "idle after write abort",
            {pins, busy_o, dq_oe_o}, {P_NOP, 2'b00});
      end else begin
        chk(dq_oe_o && dq_o == wd[31:16], "R3", "write beat1", {dq_oe_o, dq_o}, {1'b1, wd[31:16]});
        @(negedge clk_i);
        chk(!dq_oe_o && pins == P_NOP, "R3", "write recovery nop", {dq_oe_o, pins}, {1'b0, P_NOP});
        @(negedge clk_i);
        chk(!busy_o, "R10", "idle after write", busy_o, 0);
      end
    end else begin
      repeat (CAS_LAT) @(negedge clk_i);
      if (ab == 1) begin
        abort_i = 1; #1;
        chk(pins == P_BST, "R6", "read abort D1", pins, P_BST);
        @(negedge clk_i);
        abort_i = 0;
        chk(pins == P_NOP && !busy_o, "R6", "idle after abort", {pins, busy_o}, {P_NOP, 1'b0});
        for (int k = 0; k < 3; k++) begin
          chk(!rvalid_o, "R6", "no rvalid after abort", rvalid_o, 0);
          @(negedge clk_i);
        end
      end else begin
        @(negedge clk_i);
        if (ab == 2) begin
          abort_i = 1; #1;
          chk(pins == P_BST, "R6", "read abort D2", pins, P_BST);
          @(negedge clk_i);
          abort_i = 0;
          chk(pins == P_NOP && !busy_o && !rvalid_o, "R6", "idle, no rvalid",
              {pins, busy_o, rvalid_o}, {P_NOP, 2'b00});
        end else begin
          @(negedge clk_i);
          chk(rvalid_o, "R4", "rvalid timing", rvalid_o, 1);
          chk(rdata_o == {pat(b, r, c, 1), pat(b, r, c, 0)}, (ab == 3) ? "R7" : "R4",
              "read data", rdata_o, {pat(b, r, c, 1), pat(b, r, c, 0)});
          chk(!busy_o, "R10", "idle with rvalid", busy_o, 0);
          @(negedge clk_i);
          chk(!rvalid_o, "R4", "rvalid one cycle", rvalid_o, 0);
        end
      end
    end
  endtask

  // {we, bank, row, col, wdata}
  localparam logic [54:0] TBL [6] = '{
    {1'b1, 2'd0, 12'h005, 8'h0A, 32'hA5A5_1234},
    {1'b0, 2'd0, 12'h005, 8'h0A, 32'h0},
    {1'b0, 2'd0, 12'h005, 8'h0B, 32'h0},
    {1'b1, 2'd3, 12'hFFF, 8'hFF, 32'hFFFF_0000},
    {1'b0, 2'd3, 12'hFFF, 8'hFF, 32'h0},
    {1'b0, 2'd1, 12'h000, 8'h00, 32'h0}
  };

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    int r1, r2, other, a1, a2, r3;
    repeat (3) @(negedge clk_i);
    chk(pins == P_NOP && !busy_o && !rvalid_o && !dq_oe_o, "R11", "reset state",
        {pins, busy_o, rvalid_o, dq_oe_o}, {P_NOP, 3'b000});
    rst_ni = 1;
    @(negedge clk_i);
    chk(pins == P_NOP && !busy_o, "R11", "idle after reset", {pins, busy_o}, {P_NOP, 1'b0});

    for (int i = 0; i < 6; i++)
      do_acc(TBL[i][54], TBL[i][53:52], TBL[i][51:40], TBL[i][39:32], TBL[i][31:0], 0);

    do_acc(0, 2'd2, 12'h123, 8'h44, 32'h0, 1);            // R6 read abort D1
    do_acc(0, 2'd2, 12'h124, 8'h45, 32'h0, 2);            // R6 read abort D2
    do_acc(1, 2'd1, 12'h321, 8'h10, 32'h5555_AAAA, 1);    // R6 write abort
    do_acc(0, 2'd1, 12'h321, 8'h10, 32'h0, 3);            // R7 abort outside data

    // R8: idle refresh spacing
    r1 = -1; r2 = -1; other = 0;
    for (int k = 0; k < 4000 && r2 < 0; k++) begin
      @(negedge clk_i);
      if (pins == P_REF) begin
        chk(busy_o, "R10", "busy during refresh", busy_o, 1);
        if (r1 < 0) r1 = cyc; else r2 = cyc;
      end else if (pins != P_NOP && r1 >= 0) other++;
    end
    chk(r2 - r1 == REF_INT, "R8", "refresh interval", r2 - r1, REF_INT);
    chk(other == 0, "R8", "no other command between refreshes", other, 0);

    // R9: refresh wins over a held request
    while (cyc != r2 + REF_INT - 5) @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = {2'd0, 12'h0AA, 8'h20};
    a1 = -1; a2 = -1; r3 = -1;
    for (int k = 0; k < 100 && a2 < 0; k++) begin
      @(negedge clk_i);
      if (pins == P_ACT) begin
        if (a1 < 0) a1 = cyc; else a2 = cyc;
      end
      if (pins == P_REF) r3 = cyc;
    end
    req_i = 0;
    chk(a1 >= 0 && r3 > a1 && a2 > r3, "R9", "refresh before waiting request", r3, a2);
    chk(a2 - r3 == T_RFC + 1, "R9", "activate after refresh", a2 - r3, T_RFC + 1);
    while (busy_o) @(negedge clk_i);

    done = 1;
    report();
    $finish;
  end
endmodule